// File: doc/BRIEF.md
# Partition Boundary Length Decoder

This block takes a word divided into byte lanes and a vector of gate bits, one bit for each seam between neighbouring lanes. A set gate bit cuts the word at that seam. The block works out where each partition begins and how many bytes it spans. It also gives every lane its offset inside its partition and the size of the partition that covers it. Downstream lane-parallel arithmetic can then steer carries, sign bits and saturation per lane without scanning the gate vector itself.

Internally the gate vector is widened with an implied cut below the lowest lane and another above the highest lane. A partition of length k that starts at lane l is found by matching a pattern: a cut at l, a cut at l+k, and no cut strictly between them. All outputs are purely combinational.

Top module: `partition_len_decoder`

## Requirements
- R1: Lane 0 always reports a partition start, and the partition that covers the top lane always ends at the word's upper edge.
- R2: For a lane l above 0, the start flag is high exactly when gate bit l-1 is set. Gate bit i is the seam between lane i and lane i+1.
- R3: Each lane has a length code of LANES bits, in which bit k-1 stands for a length of k bytes. Exactly one bit of the code is set when the lane's start flag is high, and the code is all zero otherwise.
- R4: At a start lane l, the coded length k is the distance to the next cut: seams l through l+k-2 are clear, and seam l+k-1 is either set or is the upper word edge.
- R5: The position index is 0 at a start lane. At every other lane it is one more than the index of the lane below.
- R6: The covering length of a lane equals the coded length of the start lane of its partition. It is identical for every lane in that partition.
- R7: For every gate pattern, the coded lengths of all start lanes add up to LANES.
- R8: With all gate bits clear, the whole word is one partition of LANES bytes. Its positions run 0 to LANES-1.
- R9: With all gate bits set, every lane is a one-byte partition with position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gate_i | input | LANES-1 | Seam cut bits, bit i between lane i and lane i+1 |
| start_o | output | LANES | Per-lane partition start flag |
| len_code_o | output | LANES*LANES | Per-lane one-hot length code, lane l at bits [l*LANES +: LANES] |
| pos_o | output | LANES*IDXW | Per-lane position index within its partition |
| span_o | output | LANES*LENW | Per-lane length of the covering partition |

## Verification
The hardest cases to reach are partitions that touch neither word edge, such as a run of two or more lanes fenced by set gates on both sides. In those cases the guard bits play no part, so an error in the internal run matching cannot hide behind them. Because the gate space has only 2^(LANES-1) values, the bench drives every pattern in turn. It compares each one with a reference model that walks the gate bits lane by lane. It also checks a few named interior-run patterns in their own tasks.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int len_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/pbd_edge_guard.sv
module pbd_edge_guard #(
  parameter int LANES = 4
) (
  input  logic [LANES-2:0] gate_i,
  output logic [LANES:0]   cut_o
);
  // cut_o[j] is the seam at the lower edge of lane j; both word edges are cuts
  always_comb begin
    cut_o[0]          = 1'b1;
    cut_o[LANES]      = 1'b1;
    cut_o[LANES-1:1]  = gate_i;
  end
endmodule

// File: rtl/pbd_run_match.sv
module pbd_run_match #(
  parameter int LANES = 4
) (
  input  logic [LANES:0]         cut_i,
  output logic [LANES-1:0]       start_o,
  output logic [LANES*LANES-1:0] code_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign start_o[l] = cut_i[l];
    for (genvar k = 1; k <= LANES; k++) begin : g_len
      if (l + k > LANES) begin : g_none
        assign code_o[l*LANES + k - 1] = 1'b0;
      end else if (k == 1) begin : g_one
        assign code_o[l*LANES + k - 1] = cut_i[l] & cut_i[l+1];
      end else begin : g_run
        // cut at both ends, no cut strictly inside
        assign code_o[l*LANES + k - 1] =
          cut_i[l] & cut_i[l+k] & ~(|cut_i[l+k-1 -: k-1]);
      end
    end
  end
endmodule

// File: rtl/pbd_lane_locate.sv
module pbd_lane_locate
  import pbd_pkg::*;
#(
  parameter int LANES = 4,
  localparam int IDXW = idx_width(LANES),
  localparam int LENW = len_width(LANES)
) (
  input  logic [LANES*LANES-1:0] code_i,
  output logic [LANES*IDXW-1:0]  pos_o,
  output logic [LANES*LENW-1:0]  span_o
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [IDXW-1:0] pos_q;
    logic [LENW-1:0] span_q;
    always_comb begin
      pos_q  = '0;
      span_q = '0;
      // exactly one start at or below j covers lane j
      for (int s = 0; s <= j; s++) begin
        for (int k = 1; k <= LANES; k++) begin
          if (code_i[s*LANES + k - 1] && (s + k > j)) begin
            pos_q  = IDXW'(j - s);
            span_q = LENW'(k);
          end
        end
      end
    end
    assign pos_o[j*IDXW +: IDXW]  = pos_q;
    assign span_o[j*LENW +: LENW] = span_q;
  end
endmodule

// File: rtl/partition_len_decoder.sv
module partition_len_decoder
  import pbd_pkg::*;
#(
  parameter int LANES = 4,
  localparam int IDXW = idx_width(LANES),
  localparam int LENW = len_width(LANES)
) (
  input  logic [LANES-2:0]       gate_i,
  output logic [LANES-1:0]       start_o,
  output logic [LANES*LANES-1:0] len_code_o,
  output logic [LANES*IDXW-1:0]  pos_o,
  output logic [LANES*LENW-1:0]  span_o
);
  logic [LANES:0] cut;

  pbd_edge_guard #(.LANES(LANES)) u_guard (
    .gate_i (gate_i),
    .cut_o  (cut)
  );

  pbd_run_match #(.LANES(LANES)) u_match (
    .cut_i   (cut),
    .start_o (start_o),
    .code_o  (len_code_o)
  );

  pbd_lane_locate #(.LANES(LANES)) u_locate (
    .code_i (len_code_o),
    .pos_o  (pos_o),
    .span_o (span_o)
  );
endmodule

// File: rtl/pbd_checker.sv
module pbd_checker
  import pbd_pkg::*;
#(
  parameter int LANES = 4,
  localparam int IDXW = idx_width(LANES),
  localparam int LENW = len_width(LANES)
) (
  input logic [LANES-2:0]       gate_i,
  input logic [LANES-1:0]       start_o,
  input logic [LANES*LANES-1:0] len_code_o,
  input logic [LANES*IDXW-1:0]  pos_o,
  input logic [LANES*LENW-1:0]  span_o
);
  always_comb begin
    int total;
    total = 0;
    p_lane0_start_r1: assert (start_o[0]);
    for (int l = 0; l < LANES; l++) begin
      p_code_onehot_r3: assert ($onehot0(len_code_o[l*LANES +: LANES]));
      p_code_iff_start_r3: assert (start_o[l] == (|len_code_o[l*LANES +: LANES]));
      if (start_o[l]) begin
        p_pos_zero_r5: assert (pos_o[l*IDXW +: IDXW] == '0);
        for (int k = 1; k <= LANES; k++) begin
          if (len_code_o[l*LANES + k - 1]) begin
            total = total + k;
            p_span_at_start_r6: assert (int'(span_o[l*LENW +: LENW]) == k);
          end
        end
      end
      if (l > 0) begin
        p_start_gate_r2: assert (start_o[l] == gate_i[l-1]);
        if (!start_o[l]) begin
          p_pos_step_r5: assert (int'(pos_o[l*IDXW +: IDXW]) ==
                                 int'(pos_o[(l-1)*IDXW +: IDXW]) + 1);
          p_span_same_r6: assert (span_o[l*LENW +: LENW] ==
                                  span_o[(l-1)*LENW +: LENW]);
        end
      end
    end
    p_tile_sum_r7: assert (total == LANES);
  end
endmodule

bind partition_len_decoder pbd_checker #(.LANES(LANES)) u_chk (
  .gate_i     (gate_i),
  .start_o    (start_o),
  .len_code_o (len_code_o),
  .pos_o      (pos_o),
  .span_o     (span_o)
);

// File: tb/partition_len_decoder_tb.sv
module partition_len_decoder_tb;
  localparam int LANES = 4;
  localparam int IDXW  = pbd_pkg::idx_width(LANES);
  localparam int LENW  = pbd_pkg::len_width(LANES);

  logic clk;
  logic [LANES-2:0]       gate;
  logic [LANES-1:0]       start;
  logic [LANES*LANES-1:0] code;
  logic [LANES*IDXW-1:0]  pos;
  logic [LANES*LENW-1:0]  span;
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  partition_len_decoder #(.LANES(LANES)) u_dut (
    .gate_i(gate), .start_o(start), .len_code_o(code), .pos_o(pos), .span_o(span)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // sequential reference: walk lanes, cut at lane 0 or set gate below lane
  task automatic ref_compare(input string req);
    int rs [LANES];
    int rl [LANES];
    int rp [LANES];
    int cur_s;
    int sum;
    cur_s = 0;
    sum = 0;
    for (int l = 0; l < LANES; l++) begin
      if (l > 0 && gate[l-1]) cur_s = l;
      rs[l] = (l == cur_s) ? 1 : 0;
      rp[l] = l - cur_s;
    end
    for (int l = 0; l < LANES; l++) begin
      int e;
      e = l - rp[l];
      while (e + 1 < LANES && !gate[e]) e++;
      rl[l] = e - (l - rp[l]) + 1;
    end
    @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      int exp_code;
      exp_code = rs[l] ? (1 << (rl[l] - 1)) : 0;
      chk(req, $sformatf("g=%b lane%0d start", gate, l), int'(start[l]), rs[l]);
      chk(req, $sformatf("g=%b lane%0d code", gate, l),
          int'(code[l*LANES +: LANES]), exp_code);
      chk(req, $sformatf("g=%b lane%0d pos", gate, l), int'(pos[l*IDXW +: IDXW]), rp[l]);
      chk(req, $sformatf("g=%b lane%0d span", gate, l), int'(span[l*LENW +: LENW]), rl[l]);
      if (start[l]) begin
        for (int k = 1; k <= LANES; k++) if (code[l*LANES + k - 1]) sum += k;
      end
    end
    chk("R7", $sformatf("g=%b tile sum", gate), sum, LANES);
  endtask

  task automatic t_idle_state;
    gate = '0;
    @(negedge clk);
    chk("R1", "lane0 start at power-up", int'(start[0]), 1);
    chk("R8", "single partition code", int'(code[0 +: LANES]), 1 << (LANES - 1));
  endtask

  task automatic t_all_clear;
    gate = '0;
    ref_compare("R8");
    chk("R8", "top lane pos", int'(pos[(LANES-1)*IDXW +: IDXW]), LANES - 1);
  endtask

  task automatic t_all_set;
    gate = '1;
    ref_compare("R9");
    for (int l = 0; l < LANES; l++)
      chk("R9", $sformatf("lane%0d length one", l), int'(code[l*LANES +: LANES]), 1);
  endtask

  task automatic t_interior_run;
    // seams 0 and 2 set: lanes 1..2 form a fenced two-byte run
    gate = 3'b101;
    ref_compare("R4");
    chk("R4", "interior run length", int'(code[1*LANES +: LANES]), 2);
    chk("R6", "interior span lane2", int'(span[2*LENW +: LENW]), 2);
    chk("R1", "top lane single", int'(code[3*LANES +: LANES]), 1);
  endtask

  task automatic t_sweep;
    for (int g = 0; g < (1 << (LANES - 1)); g++) begin
      gate = (LANES-1)'(g);
      ref_compare("R2");
      ref_compare("R3");
      ref_compare("R5");
      ref_compare("R6");
    end
  endtask

  initial begin
    t_idle_state();
    t_all_clear();
    t_all_set();
    t_interior_run();
    t_sweep();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule